// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block holds a small set of address-range registers that guard a serial flash device, and it screens every flash cycle against them before that cycle is allowed to start. Each range register names a first and a last 4 KiB page and carries two independent enables: one that forbids program and erase cycles inside the range, and one that forbids reads inside it. A range covers every byte from the first address of its lower page to the last address of its upper page.

Software fills in the range registers while the block is open, then sets a lockdown bit. From that moment the ranges are enforced and can no longer be changed until the next reset. Writes that arrive after lockdown are dropped without any indication. Before lockdown every cycle is let through, whatever the registers hold.

The flash sequencer presents a request strobe with the 25-bit flash address and the access kind. One clock later the block answers with either a grant or a block. Any block also raises an error flag that stays set until reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, rsp_valid, rsp_grant, rsp_block, err_flag and locked are all 0, and every range has both enables cleared.
- R2: A request sampled with req_valid high at a clock edge is answered at that edge: rsp_valid is 1 for exactly that cycle, and exactly one of rsp_grant and rsp_block is 1. When rsp_valid is 0, both rsp_grant and rsp_block are 0.
- R3: While locked is 0, every request is granted, whatever the range registers contain.
- R4: The 32-bit range word places the write/erase enable at bit 31, the upper page number at bits 28:16, the read enable at bit 15 and the lower page number at bits 12:0. Bits 30:29 and 14:13 have no effect.
- R5: A range covers the inclusive byte span from {lower,12'h000} to {upper,12'hFFF}. The byte just below the span and the byte just above it are not covered.
- R6: A request with req_write=1 (program or erase) is checked against the write/erase enables only. A request with req_write=0 (read) is checked against the read enables only.
- R7: There are five ranges, selected by cfg_idx values 0 to 4. Once locked, a request is blocked if any enabled range of the matching kind covers its address.
- R8: A range whose lower page is greater than its upper page covers no address.
- R9: lock_set sets locked, and locked stays 1 until reset. A range write while locked is 0 takes effect at that clock edge. A range write while locked is 1 changes nothing.
- R10: A blocked response sets err_flag, which stays 1 until reset. Granted responses leave err_flag unchanged.
- R11: The address is compared as an unsigned 25-bit value, so the topmost address 0x1FFFFFF can be protected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register index, 0 to 4 |
| cfg_wdata | input | 32 | Range register write data |
| lock_set | input | 1 | Sets the lockdown bit |
| req_valid | input | 1 | Flash cycle request strobe |
| req_addr | input | 25 | Flash byte address of the request |
| req_write | input | 1 | 1 = program or erase, 0 = read |
| rsp_valid | output | 1 | Decision valid, one clock after the request |
| rsp_grant | output | 1 | Cycle may start |
| rsp_block | output | 1 | Cycle is refused |
| err_flag | output | 1 | Sticky: some request was blocked |
| locked | output | 1 | Lockdown state |

## Verification
The bench builds the block with its default parameters: five ranges, a 25-bit address and a 4 KiB page. With these values the page field fills all 13 bits. This allows a range at page 0x1FFF that reaches the very top of the address space. It also allows the reserved bits next to both page fields to be set, to show they are ignored. Each range index is programmed with a different shape: write-only, read-only, both enables, an inverted range, and junk in the reserved bits. This exercises the OR over ranges, the kind selection and both inclusive edges of a span. Lockdown is then checked both through requests against ranges that were rewritten after locking and through a second reset that reopens the block.

// File: rtl/frg_pkg.sv
package frg_pkg;
   // Field positions of a range word; software depends on them.
   localparam int RANGE_WORD_W = 32;
   localparam int WP_BIT       = 31;
   localparam int RP_BIT       = 15;
   localparam int UPPER_LSB    = 16;
   localparam int LOWER_LSB    = 0;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/frg_range_reg.sv
module frg_range_reg #(
   parameter int PN_W = 13
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_i,
   input  logic                                lock_i,
   input  logic [frg_pkg::RANGE_WORD_W-1:0]   wdata_i,
   output logic                                wp_o,
   output logic                                rp_o,
   output logic [PN_W-1:0]                     lo_o,
   output logic [PN_W-1:0]                     hi_o
);
   import frg_pkg::*;

   localparam logic [RANGE_WORD_W-1:0] PN_ONES   = {{(RANGE_WORD_W-PN_W){1'b0}}, {PN_W{1'b1}}};
   localparam logic [RANGE_WORD_W-1:0] USED_MASK = (PN_ONES << UPPER_LSB) | (PN_ONES << LOWER_LSB)
                                                 | (RANGE_WORD_W'(1) << WP_BIT)
                                                 | (RANGE_WORD_W'(1) << RP_BIT);

   logic wdata_unused;
   assign wdata_unused = ^(wdata_i & ~USED_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_o <= 1'b0;
         rp_o <= 1'b0;
         lo_o <= '0;
         hi_o <= '0;
      end else if (wr_i && !lock_i) begin
         wp_o <= wdata_i[WP_BIT];
         rp_o <= wdata_i[RP_BIT];
         lo_o <= wdata_i[LOWER_LSB +: PN_W];
         hi_o <= wdata_i[UPPER_LSB +: PN_W];
      end
   end

   // R9
   range_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ($stable(wp_o) && $stable(rp_o) && $stable(lo_o) && $stable(hi_o)));
endmodule

// File: rtl/frg_range_cmp.sv
module frg_range_cmp #(
   parameter int PN_W = 13
) (
   input  logic                 wp_i,
   input  logic                 rp_i,
   input  logic [PN_W-1:0]      lo_i,
   input  logic [PN_W-1:0]      hi_i,
   input  logic [PN_W-1:0]      page_i,
   input  frg_pkg::acc_kind_e   kind_i,
   output logic                 hit_o
);
   import frg_pkg::*;

   logic in_span;
   logic armed;

   // Unsigned page compare equals a byte compare with padded bounds.
   assign in_span = (page_i >= lo_i) && (page_i <= hi_i);
   assign armed   = (kind_i == ACC_WRITE) ? wp_i : rp_i;
   assign hit_o   = in_span && armed;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard #(
   parameter int NUM_RANGES = 5,
   parameter int ADDR_W     = 25,
   parameter int PAGE_OFF_W = 12,
   localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [IDX_W-1:0]                  cfg_idx,
   input  logic [frg_pkg::RANGE_WORD_W-1:0]  cfg_wdata,
   input  logic                              lock_set,
   input  logic                              req_valid,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic                              req_write,
   output logic                              rsp_valid,
   output logic                              rsp_grant,
   output logic                              rsp_block,
   output logic                              err_flag,
   output logic                              locked
);
   import frg_pkg::*;

   localparam int PN_W = ADDR_W - PAGE_OFF_W;

   generate
      if (PN_W < 1 || PN_W > RP_BIT - LOWER_LSB || PN_W > WP_BIT - UPPER_LSB) begin : g_bad_pn_w
         $error("page number width does not fit the range word");
      end
      if (NUM_RANGES < 1) begin : g_bad_num
         $error("at least one range is required");
      end
   endgenerate

   logic [PN_W-1:0]       page;
   acc_kind_e             kind;
   logic [NUM_RANGES-1:0] hits;
   logic                  any_hit;
   logic                  refuse;
   logic                  addr_unused;

   assign page        = req_addr[ADDR_W-1:PAGE_OFF_W];
   assign addr_unused = ^req_addr[PAGE_OFF_W-1:0];
   assign kind        = acc_kind_e'(req_write);

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_range
      logic            wp, rp;
      logic [PN_W-1:0] lo, hi;

      frg_range_reg #(.PN_W(PN_W)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_i   (cfg_we && (cfg_idx == IDX_W'(i))),
         .lock_i (locked),
         .wdata_i(cfg_wdata),
         .wp_o   (wp),
         .rp_o   (rp),
         .lo_o   (lo),
         .hi_o   (hi)
      );

      frg_range_cmp #(.PN_W(PN_W)) u_cmp (
         .wp_i  (wp),
         .rp_i  (rp),
         .lo_i  (lo),
         .hi_i  (hi),
         .page_i(page),
         .kind_i(kind),
         .hit_o (hits[i])
      );
   end

   assign any_hit = |hits;
   assign refuse  = locked && any_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (lock_set) begin
         locked <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_block <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && !refuse;
         rsp_block <= req_valid && refuse;
         if (req_valid && refuse) begin
            err_flag <= 1'b1;
         end
      end
   end

   // R2
   one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_grant != rsp_block));
   // R2
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_grant && !rsp_block));
   // R2
   answer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R3
   open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !locked) |=> rsp_grant);
   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
   // R10
   block_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_block |-> err_flag);
endmodule

// File: tb/tb_flash_range_guard.sv
module tb_flash_range_guard;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_idx;
   logic [31:0] cfg_wdata;
   logic        lock_set;
   logic        req_valid;
   logic [24:0] req_addr;
   logic        req_write;
   logic        rsp_valid, rsp_grant, rsp_block, err_flag, locked;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_range_guard dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .lock_set(lock_set), .req_valid(req_valid),
      .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .rsp_block(rsp_block), .err_flag(err_flag),
      .locked(locked)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
      lock_set = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input logic [2:0] idx, input logic [31:0] word);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = word;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_lock();
      @(negedge clk);
      lock_set = 1'b1;
      @(negedge clk);
      lock_set = 1'b0;
   endtask

   // Issue one request; the answer is registered at the next posedge.
   task automatic do_req(input string tag, input logic [24:0] a, input bit wr, input bit exp_block);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " block"}, {31'd0, rsp_block}, {31'd0, exp_block});
      chk({tag, " grant"}, {31'd0, rsp_grant}, {31'd0, !exp_block});
   endtask

   task automatic t_reset_state();
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1 grant/block", {30'd0, rsp_grant, rsp_block}, 32'd0);
      chk("R1 err_flag", {31'd0, err_flag}, 32'd0);
      chk("R1 locked", {31'd0, locked}, 32'd0);
   endtask

   task automatic t_open_phase();
      cfg_write(3'd0, 32'h801F_0010);
      cfg_write(3'd1, 32'h0100_8100);
      cfg_write(3'd2, 32'h9FFF_9FFF);
      cfg_write(3'd3, 32'h8040_8050);
      cfg_write(3'd4, 32'hE081_6080);
      do_req("R3 open write in range0", 25'h001_0000, 1'b1, 1'b0);
      do_req("R3 open read in range1", 25'h010_0ABC, 1'b0, 1'b0);
      @(negedge clk);
      chk("R2 valid drops after one cycle", {31'd0, rsp_valid}, 32'd0);
      chk("R2 idle grant/block", {30'd0, rsp_grant, rsp_block}, 32'd0);
   endtask

   task automatic t_lock_and_bounds();
      do_lock();
      chk("R9 locked set", {31'd0, locked}, 32'd1);
      do_req("R5 below range0", 25'h000_FFFF, 1'b1, 1'b0);
      do_req("R5 above range0", 25'h002_0000, 1'b1, 1'b0);
      chk("R10 err clear after grants", {31'd0, err_flag}, 32'd0);
      do_req("R5 first byte range0", 25'h001_0000, 1'b1, 1'b1);
      chk("R10 err set by block", {31'd0, err_flag}, 32'd1);
      do_req("R5 last byte range0", 25'h001_FFFF, 1'b1, 1'b1);
      do_req("R10 grant keeps err", 25'h003_0000, 1'b0, 1'b0);
      chk("R10 err sticky", {31'd0, err_flag}, 32'd1);
   endtask

   task automatic t_kinds_and_ranges();
      do_req("R6 read in write-only range0", 25'h001_8000, 1'b0, 1'b0);
      do_req("R6 read in read-only range1", 25'h010_0ABC, 1'b0, 1'b1);
      do_req("R6 write in read-only range1", 25'h010_0ABC, 1'b1, 1'b0);
      do_req("R11 top address read range2", 25'h1FF_FFFF, 1'b0, 1'b1);
      do_req("R11 top address write range2", 25'h1FF_F000, 1'b1, 1'b1);
      do_req("R11 below range2", 25'h1FF_EFFF, 1'b0, 1'b0);
      do_req("R8 inverted range3 read", 25'h004_5000, 1'b0, 1'b0);
      do_req("R8 inverted range3 write", 25'h005_0000, 1'b1, 1'b0);
      do_req("R7 range4 write last page", 25'h008_1FFF, 1'b1, 1'b1);
      do_req("R4 range4 reserved bits no read enable", 25'h008_1000, 1'b0, 1'b0);
      do_req("R7 above range4", 25'h008_2000, 1'b1, 1'b0);
   endtask

   task automatic t_locked_writes();
      cfg_write(3'd0, 32'h0000_0000);
      cfg_write(3'd3, 32'h8300_0300);
      do_lock();
      chk("R9 still locked", {31'd0, locked}, 32'd1);
      do_req("R9 range0 kept after dropped write", 25'h001_0000, 1'b1, 1'b1);
      do_req("R9 range3 write dropped", 25'h030_0000, 1'b1, 1'b0);
   endtask

   task automatic t_rereset();
      do_reset();
      @(negedge clk);
      t_reset_state();
      do_lock();
      do_req("R1 ranges cleared by reset", 25'h001_0000, 1'b1, 1'b0);
      do_req("R1 top address cleared by reset", 25'h1FF_FFFF, 1'b0, 1'b0);
      chk("R10 no err after reset", {31'd0, err_flag}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0;
      do_reset();
      @(negedge clk);
      t_reset_state();
      t_open_phase();
      t_lock_and_bounds();
      t_kinds_and_ranges();
      t_locked_writes();
      t_rereset();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule